// File: doc/BRIEF.md
# Four-Channel Interval Timer and Event Counter

This peripheral holds four independent 8-bit down-counters. The host talks to it over an 8-bit write bus with a select, a read strobe, a write strobe and a 2-bit channel number. Each channel either divides the system clock through a prescaler (timer mode) or counts edges of its own trigger input (counter mode). A timer can instead be told to wait for a trigger edge before it starts. When a count reaches zero, the channel reloads its time constant and keeps running. Channels 0 to 2 also give a one-clock pulse on a zero-count output. If enabled, the channel raises a vectored interrupt.

Interrupts pass through a priority daisy chain with an enable input and an enable output, so several of these blocks can be chained. Channel 0 has the highest priority. An acknowledge pulse moves the highest pending channel that is allowed to request into service and returns its vector. A return pulse ends service of the channel that currently holds the chain.

Each channel has a four-state controller:
- STOP: idle, counter frozen.
- LOAD: waiting for a time constant.
- ARM: loaded and waiting for a trigger edge.
- RUN: counting.

Its transitions are:
- STOP to LOAD on a control word asking for a time constant.
- LOAD to RUN, or LOAD to ARM when a triggered-start timer was chosen, on the time-constant write.
- ARM to RUN on the selected trigger edge.
- ARM or RUN to STOP on a software-reset control word, or to LOAD when that word also asks for a time constant.

Top module: `quad_tick_timer`

## Requirements
- R1: After reset every channel is in STOP and reads back 0. The zero-count outputs are low, `irq` is low, and `ien_out` follows `ien_in`.
- R2: The way a write is taken depends on the channel and the byte:
  - A write to a channel that expects a time constant is its time constant, whatever its value.
  - Otherwise a byte with bit 0 = 1 is a control word. Its bits are: 1 software reset, 2 time constant follows, 3 timer waits for trigger, 4 rising edge (0 = falling), 5 divide by 256 (0 = by 16), 6 counter mode (0 = timer), 7 interrupt enable.
  - A byte with bit 0 = 0 to channel 1, 2 or 3 has no effect.
  - A time constant of 0 counts as 256.
- R3: In timer mode the counter steps down once every 16 clocks, or every 256 clocks when bit 5 was set. The first step comes 16 (or 256) clocks after the time-constant write.
- R4: Stepping down from 1 reloads the time constant in the same clock, and counting goes on without host action.
- R5: In counter mode the counter steps down once per trigger edge of the selected polarity. Edges of the other polarity are ignored.
- R6: A timer with bit 3 set stays loaded and does not count until the selected trigger edge. It steps down 16 clocks after that edge.
- R7: For channels 0 to 2, `zc[i]` is high for exactly one clock after each reload. Channel 3 has no such output.
- R8: A software-reset control word stops the channel and freezes its counter. Once it is stopped, only a new time constant restarts it.
- R9: A byte with bit 0 = 0 written to channel 0, when that channel does not expect a time constant, sets vector bits 7:3. The vector returned for channel n has bits 2:1 = n and bit 0 = 0.
- R10: A channel with a pending or in-service interrupt drives the chain low for all lower channels. `iack` puts the requesting channel into service and `ivec` shows its vector. `reti` ends service of the in-service channel that holds the chain.
- R11: With `ien_in` low, `irq` and `ien_out` are low.
- R12: The host can read a channel's current count at any time, while it runs or while it is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sel | input | 1 | Block select |
| rd | input | 1 | Read strobe; `rdata` shows the count of `chan` |
| wr | input | 1 | Write strobe, one clock per byte |
| chan | input | 2 | Channel number for reads and writes |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Count of the selected channel, 0 when not reading |
| trg | input | 4 | Per-channel trigger / count input |
| zc | output | 3 | Zero-count pulses of channels 0 to 2 |
| ien_in | input | 1 | Daisy-chain enable from the higher-priority neighbour |
| ien_out | output | 1 | Daisy-chain enable to the lower-priority neighbour |
| irq | output | 1 | Interrupt request |
| iack | input | 1 | Interrupt acknowledge pulse |
| reti | input | 1 | Return-from-interrupt pulse |
| ivec | output | 8 | Vector of the requesting channel |

## Verification
The count path is tried with prescaled timers of both ratios, sampled one clock before and at the expected step. This separates the two ratios from each other and from an off-by-one step. Trigger inputs are toggled in both directions under both edge settings, which shows whether polarity is decoded or ignored. A time constant of 0 tells a 256 wrap apart from a stuck counter. The interrupt chain is driven with two channels pending in the reverse of their priority order, then with the chain enable removed. This shows whether priority, blocking during service and the return pulse each act on the correct channel.

// File: rtl/qtt_pkg.sv
package qtt_pkg;
    // control word bit positions (bit 0 marks a control word)
    localparam int CW_CTL    = 0;
    localparam int CW_RST    = 1;
    localparam int CW_TCF    = 2;
    localparam int CW_TSTART = 3;
    localparam int CW_RISE   = 4;
    localparam int CW_P256   = 5;
    localparam int CW_CNT    = 6;
    localparam int CW_IE     = 7;

    typedef enum logic [1:0] {
        ST_STOP,
        ST_LOAD,
        ST_ARM,
        ST_RUN
    } chan_state_t;

    typedef struct packed {
        logic ie;
        logic cnt_mode;
        logic pre_long;
        logic rising;
        logic trig_start;
    } chan_cfg_t;
endpackage

// File: rtl/qtt_edge.sv
module qtt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic rising,
    output logic hit
);
    logic din_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    assign hit = rising ? (din & ~din_q) : (~din & din_q);
endmodule

// File: rtl/qtt_prescale.sv
module qtt_prescale #(
    parameter int PRE_SHORT = 16,
    parameter int PRE_LONG  = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic long_sel,
    output logic tick
);
    localparam int PW = $clog2(PRE_LONG);

    logic [PW-1:0] pc_q;
    logic [PW-1:0] lim;

    assign lim  = long_sel ? PW'(PRE_LONG - 1) : PW'(PRE_SHORT - 1);
    assign tick = run && (pc_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pc_q <= '0;
        else if (!run) pc_q <= '0;
        else if (tick) pc_q <= '0;
        else           pc_q <= pc_q + 1'b1;
    end
endmodule

// File: rtl/qtt_irq_link.sv
module qtt_irq_link (
    input  logic ie_in,
    input  logic pend,
    input  logic busy,
    output logic req,
    output logic ie_out,
    output logic ret_ok
);
    assign req    = ie_in & pend & ~busy;
    assign ie_out = ie_in & ~pend & ~busy;
    assign ret_ok = ie_in & busy;
endmodule

// File: rtl/qtt_channel.sv
module qtt_channel
    import qtt_pkg::*;
#(
    parameter int DW        = 8,
    parameter int PRE_SHORT = 16,
    parameter int PRE_LONG  = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctl,
    input  logic          wr_tc,
    input  logic [DW-1:0] wdata,
    input  logic          trg,
    input  logic          iack_hit,
    input  logic          reti_hit,
    output logic [DW-1:0] cnt,
    output logic          tc_expect,
    output logic          zero_pulse,
    output logic          ip,
    output logic          ius
);
    chan_state_t   st_q, st_d;
    chan_cfg_t     cfg_q, cfg_wr;
    logic          tcp_q;
    logic [DW-1:0] tc_q, cnt_q;
    logic          zp_q, ip_q, ius_q;
    logic          sw_rst, tcf, edge_hit, pre_tick, pre_run, tick, at_one;

    assign sw_rst  = wr_ctl & wdata[CW_RST];
    assign tcf     = wr_ctl & wdata[CW_TCF];
    assign pre_run = (st_q == ST_RUN) && !cfg_q.cnt_mode;
    assign tick    = (st_q == ST_RUN) && (cfg_q.cnt_mode ? edge_hit : pre_tick);
    assign at_one  = (cnt_q == DW'(1));

    always_comb begin
        cfg_wr.ie         = wdata[CW_IE];
        cfg_wr.cnt_mode   = wdata[CW_CNT];
        cfg_wr.pre_long   = wdata[CW_P256];
        cfg_wr.rising     = wdata[CW_RISE];
        cfg_wr.trig_start = wdata[CW_TSTART];
    end

    qtt_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (trg),
        .rising (cfg_q.rising),
        .hit    (edge_hit)
    );

    qtt_prescale #(
        .PRE_SHORT (PRE_SHORT),
        .PRE_LONG  (PRE_LONG)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (pre_run),
        .long_sel (cfg_q.pre_long),
        .tick     (pre_tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STOP;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_STOP: begin
                if (tcf) st_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (wr_tc)
                    st_d = (!cfg_q.cnt_mode && cfg_q.trig_start) ? ST_ARM : ST_RUN;
            end
            ST_ARM: begin
                if (sw_rst)        st_d = tcf ? ST_LOAD : ST_STOP;
                else if (edge_hit) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (sw_rst) st_d = tcf ? ST_LOAD : ST_STOP;
            end
            default: st_d = ST_STOP;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            tcp_q <= 1'b0;
            tc_q  <= '0;
            cnt_q <= '0;
            zp_q  <= 1'b0;
            ip_q  <= 1'b0;
            ius_q <= 1'b0;
        end else begin
            zp_q <= 1'b0;
            if (wr_ctl) begin
                cfg_q <= cfg_wr;
                if (wdata[CW_TCF]) tcp_q <= 1'b1;
            end
            if (wr_tc) begin
                tc_q  <= wdata;
                tcp_q <= 1'b0;
                if (st_q == ST_LOAD) cnt_q <= wdata;
            end else if (tick) begin
                if (at_one) begin
                    cnt_q <= tc_q;
                    zp_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (sw_rst) ip_q <= 1'b0;
            else        ip_q <= (ip_q & ~iack_hit) | (tick & at_one & cfg_q.ie);
            ius_q <= (ius_q & ~reti_hit) | iack_hit;
        end
    end

    assign cnt        = cnt_q;
    assign tc_expect  = tcp_q;
    assign zero_pulse = zp_q;
    assign ip         = ip_q;
    assign ius        = ius_q;
endmodule

// File: rtl/quad_tick_timer.sv
module quad_tick_timer
    import qtt_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DW        = 8,
    parameter int NUM_ZC    = 3,
    parameter int PRE_SHORT = 16,
    parameter int PRE_LONG  = 256,
    parameter int SEL_W     = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [SEL_W-1:0]  chan,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NUM_CH-1:0] trg,
    output logic [NUM_ZC-1:0] zc,
    input  logic              ien_in,
    output logic              ien_out,
    output logic              irq,
    input  logic              iack,
    input  logic              reti,
    output logic [DW-1:0]     ivec
);
    localparam int VHW = DW - SEL_W - 1;

    logic [NUM_CH-1:0] tc_exp, zp, ip, ius, req, ret_ok, ack_hit, ret_hit;
    logic [NUM_CH-1:0] wr_ctl, wr_tc;
    logic [NUM_CH:0]   ie_chain;
    logic [DW-1:0]     cnt [NUM_CH];
    logic              wr_stb, vec_wr;
    logic [VHW-1:0]    vhi_q;
    logic [SEL_W-1:0]  req_code;

    assign wr_stb = sel & wr;
    assign vec_wr = wr_stb && (chan == '0) && !tc_exp[0] && !wdata[CW_CTL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      vhi_q <= '0;
        else if (vec_wr) vhi_q <= wdata[DW-1:SEL_W+1];
    end

    assign ie_chain[0] = ien_in;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit       = wr_stb && (chan == SEL_W'(g));
        assign wr_tc[g]  = hit && tc_exp[g];
        assign wr_ctl[g] = hit && !tc_exp[g] && wdata[CW_CTL];
        assign ack_hit[g] = iack & req[g];
        assign ret_hit[g] = reti & ret_ok[g];

        qtt_channel #(
            .DW        (DW),
            .PRE_SHORT (PRE_SHORT),
            .PRE_LONG  (PRE_LONG)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_ctl     (wr_ctl[g]),
            .wr_tc      (wr_tc[g]),
            .wdata      (wdata),
            .trg        (trg[g]),
            .iack_hit   (ack_hit[g]),
            .reti_hit   (ret_hit[g]),
            .cnt        (cnt[g]),
            .tc_expect  (tc_exp[g]),
            .zero_pulse (zp[g]),
            .ip         (ip[g]),
            .ius        (ius[g])
        );

        qtt_irq_link u_link (
            .ie_in  (ie_chain[g]),
            .pend   (ip[g]),
            .busy   (ius[g]),
            .req    (req[g]),
            .ie_out (ie_chain[g+1]),
            .ret_ok (ret_ok[g])
        );
    end

    for (genvar z = 0; z < NUM_ZC; z++) begin : g_zc
        assign zc[z] = zp[z];
    end

    logic unused_zp;
    assign unused_zp = &{1'b0, zp};

    assign ien_out = ie_chain[NUM_CH];
    assign irq     = |req;

    always_comb begin
        req_code = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) req_code = SEL_W'(i);
        end
    end

    assign ivec = {vhi_q, req_code, 1'b0};

    always_comb begin
        rdata = '0;
        if (sel && rd) rdata = cnt[chan];
    end
endmodule

// File: rtl/qtt_checker.sv
module qtt_checker #(
    parameter int NUM_ZC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              ien_in,
    input logic              ien_out,
    input logic              iack,
    input logic [NUM_ZC-1:0] zc
);
    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_in |-> (!irq && !ien_out))
        else $error("irq or ien_out while chain enable is low");

    assert_chain_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ien_out |-> ien_in)
        else $error("ien_out high without ien_in");

    assert_irq_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !ien_out)
        else $error("requesting block left chain open");

    assert_ack_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && irq) |=> !ien_out)
        else $error("acknowledged channel did not hold the chain");

    for (genvar z = 0; z < NUM_ZC; z++) begin : g_zc_chk
        assert_zc_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
            zc[z] |=> !zc[z])
            else $error("zero-count pulse longer than one clock");
    end
endmodule

bind quad_tick_timer qtt_checker #(.NUM_ZC(NUM_ZC)) u_qtt_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .ien_in  (ien_in),
    .ien_out (ien_out),
    .iack    (iack),
    .zc      (zc)
);

// File: tb/tb_quad_tick_timer.sv
`timescale 1ns/1ps
module tb_quad_tick_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] chan = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] trg = '0;
    logic [2:0] zc;
    logic       ien_in = 1'b1;
    logic       ien_out, irq;
    logic       iack = 1'b0, reti = 1'b0;
    logic [7:0] ivec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    quad_tick_timer dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .chan(chan),
        .wdata(wdata), .rdata(rdata), .trg(trg), .zc(zc), .ien_in(ien_in),
        .ien_out(ien_out), .irq(irq), .iack(iack), .reti(reti), .ivec(ivec)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [1:0] c, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; chan = c; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_cnt(input logic [1:0] c, output int v);
        sel = 1'b1; rd = 1'b1; chan = c;
        #1 v = int'(rdata);
        sel = 1'b0; rd = 1'b0;
    endtask

    task automatic pulse_trg(input int i);
        trg[i] = ~trg[i];
        @(negedge clk);
    endtask

    task automatic do_iack(output int v);
        @(negedge clk);
        iack = 1'b1;
        #1 v = int'(ivec);
        @(negedge clk);
        iack = 1'b0;
    endtask

    task automatic do_reti();
        @(negedge clk);
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        for (int c = 0; c < 4; c++) begin
            rd_cnt(2'(c), v);
            check("R1", "count after reset", v, 0);
        end
        check("R1", "zc after reset", int'(zc), 0);
        check("R1", "irq after reset", int'(irq), 0);
        check("R1", "ien_out after reset", int'(ien_out), 1);
    endtask

    task automatic t_timer16();
        int v;
        wr_byte(2'd0, 8'h05);
        wr_byte(2'd0, 8'd3);
        idle(15); rd_cnt(2'd0, v); check("R3", "div16 before step", v, 3);
        idle(1);  rd_cnt(2'd0, v); check("R3", "div16 at step", v, 2);
        idle(16); rd_cnt(2'd0, v); check("R12", "read while running", v, 1);
        idle(16); rd_cnt(2'd0, v); check("R4", "reload after zero", v, 3);
        idle(16); rd_cnt(2'd0, v); check("R4", "keeps counting", v, 2);
    endtask

    task automatic t_swreset_stop();
        int a, b;
        wr_byte(2'd0, 8'h03);
        rd_cnt(2'd0, a);
        idle(300);
        rd_cnt(2'd0, b);
        check("R8", "frozen after software reset", b, a);
    endtask

    task automatic t_timer256();
        int v;
        wr_byte(2'd1, 8'h25);
        wr_byte(2'd1, 8'd2);
        idle(255); rd_cnt(2'd1, v); check("R3", "div256 before step", v, 2);
        idle(1);   rd_cnt(2'd1, v); check("R3", "div256 at step", v, 1);
        wr_byte(2'd1, 8'h03);
    endtask

    task automatic t_zero_pulse();
        int v;
        wr_byte(2'd1, 8'h05);
        wr_byte(2'd1, 8'd2);
        idle(31); check("R7", "zc before zero", int'(zc[1]), 0);
        idle(1);  check("R7", "zc at zero", int'(zc[1]), 1);
        rd_cnt(2'd1, v); check("R4", "reloaded value", v, 2);
        idle(1);  check("R7", "zc one clock only", int'(zc[1]), 0);
        wr_byte(2'd1, 8'h03);
    endtask

    task automatic t_counter();
        int v;
        wr_byte(2'd2, 8'h55);
        wr_byte(2'd2, 8'd0);
        pulse_trg(2); rd_cnt(2'd2, v); check("R2", "tc 0 acts as 256", v, 255);
        pulse_trg(2); rd_cnt(2'd2, v); check("R5", "falling ignored in rising mode", v, 255);
        wr_byte(2'd2, 8'h47);
        wr_byte(2'd2, 8'd5);
        pulse_trg(2); rd_cnt(2'd2, v); check("R5", "rising ignored in falling mode", v, 5);
        pulse_trg(2); rd_cnt(2'd2, v); check("R5", "falling counted", v, 4);
        wr_byte(2'd2, 8'h03);
    endtask

    task automatic t_trigger();
        int v;
        wr_byte(2'd3, 8'h1D);
        wr_byte(2'd3, 8'd4);
        idle(40); rd_cnt(2'd3, v); check("R6", "armed timer holds", v, 4);
        pulse_trg(3);
        idle(15); rd_cnt(2'd3, v); check("R6", "before first step", v, 4);
        idle(1);  rd_cnt(2'd3, v); check("R6", "first step after trigger", v, 3);
        wr_byte(2'd3, 8'h03);
    endtask

    task automatic t_swreset_restart();
        int a, b;
        rd_cnt(2'd0, a);
        wr_byte(2'd0, 8'h07);
        idle(100);
        rd_cnt(2'd0, b); check("R8", "stopped until tc", b, a);
        wr_byte(2'd0, 8'd9);
        idle(16);
        rd_cnt(2'd0, b); check("R8", "restart after tc", b, 8);
    endtask

    task automatic t_interrupts();
        int v, a;
        wr_byte(2'd0, 8'hA8);
        rd_cnt(2'd1, a);
        wr_byte(2'd1, 8'h40);
        rd_cnt(2'd1, v); check("R2", "data byte to ch1 ignored", v, a);
        wr_byte(2'd0, 8'hD7); wr_byte(2'd0, 8'd1);
        wr_byte(2'd2, 8'hD7); wr_byte(2'd2, 8'd1);
        check("R10", "no request yet", int'(irq), 0);
        pulse_trg(2);
        check("R10", "ch2 requests", int'(irq), 1);
        check("R10", "chain blocked by ch2", int'(ien_out), 0);
        pulse_trg(0);
        do_iack(v); check("R9", "vector ch0 first", v, 8'hA8);
        check("R10", "in-service ch0 blocks ch2", int'(irq), 0);
        do_reti();
        check("R10", "ch2 requests after reti", int'(irq), 1);
        do_iack(v); check("R9", "vector ch2", v, 8'hAC);
        do_reti();
        check("R10", "all serviced irq", int'(irq), 0);
        check("R10", "all serviced chain open", int'(ien_out), 1);
        pulse_trg(0);
        pulse_trg(0);
        check("R11", "ch0 pending", int'(irq), 1);
        ien_in = 1'b0;
        #1 check("R11", "irq gated", int'(irq), 0);
        check("R11", "ien_out gated", int'(ien_out), 0);
        ien_in = 1'b1;
        #1 check("R11", "irq restored", int'(irq), 1);
        do_iack(v); check("R9", "vector ch0 again", v, 8'hA8);
        do_reti();
        check("R10", "cleared at end", int'(irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timer16();
        t_swreset_stop();
        t_timer256();
        t_zero_pulse();
        t_counter();
        t_trigger();
        t_swreset_restart();
        t_interrupts();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule